// File: doc/BRIEF.md
# Buffered Serial Receiver with Occupancy Trigger

This block is the receive side of an asynchronous serial port. It watches the incoming line and finds the falling edge of a start bit. It confirms that start bit halfway through the bit, then samples each data bit at its centre. The sampling rate comes from a baud tick supplied by the caller, and the block expects sixteen ticks per bit time. Every finished character goes into a sixteen-entry first-in first-out queue. The host drains that queue one byte at a time.

A data-ready interrupt stays raised while the queue occupancy is at or above a selected threshold. This lets the host service characters in bursts and not on every byte. The block keeps three sticky line-status flags:

- a parity mismatch flag,
- a missing stop bit (framing) flag,
- a queue overrun flag.

All three stay set until the host acknowledges the status.

The character format comes from static inputs: a word length of five to eight bits, an optional parity bit, and odd or even sense. The receiver checks only the first stop bit. Extra stop time on the line looks like idle.

Top module: `uart_rx_buf`

## Requirements
- R1: After reset `empty_o`=1, `level_o`=0, `irq_o`=0, and `overrun_o`, `parity_err_o` and `framing_err_o` are all 0.
- R2: `word_len_i` selects the data bits per character: 00 gives 5, 01 gives 6, 10 gives 7 and 11 gives 8. Bits arrive least significant first. Unused upper bits of `rd_data_o` read as 0.
- R3: After the line goes low, the start bit is accepted only if the line is still low at the eighth baud tick. A shorter low pulse stores nothing.
- R4: When `par_en_i`=1, one parity bit follows the data. With `par_odd_i`=0 the data and parity bits together hold an even number of ones; with `par_odd_i`=1 they hold an odd number. A mismatch sets `parity_err_o`.
- R5: A low line at the first stop-bit sample sets `framing_err_o`. The character is still stored. No new start bit is looked for until the line has returned high.
- R6: Characters leave the queue in arrival order. `rd_data_o` shows the oldest entry. A high `rd_i` removes that entry when the queue is not empty.
- R7: `trig_sel_i` sets the interrupt threshold: 00 gives 1 entry, 01 gives 4, 10 gives 8 and 11 gives 16. `irq_o` is high exactly while `level_o` is at or above the threshold.
- R8: A character that completes while 16 entries are queued sets `overrun_o` and is discarded. The 16 stored entries stay unchanged.
- R9: The three status flags stay set until `status_rd_i` is high for a cycle, which clears them. A set in the same cycle wins over the clear.
- R10: `level_o` equals the number of queued characters and never exceeds 16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| baud_tick_i | input | 1 | Sampling strobe, 16 per bit time |
| rx_i | input | 1 | Serial line, idle high |
| word_len_i | input | 2 | Data bits per character (R2 encoding) |
| par_en_i | input | 1 | Parity bit present |
| par_odd_i | input | 1 | Odd parity when 1, even when 0 |
| trig_sel_i | input | 2 | Interrupt threshold select (R7 encoding) |
| rd_i | input | 1 | Remove the oldest queued byte |
| rd_data_o | output | 8 | Oldest queued byte |
| empty_o | output | 1 | Queue holds nothing |
| level_o | output | 5 | Queue occupancy |
| irq_o | output | 1 | Occupancy at or above threshold |
| status_rd_i | input | 1 | Acknowledge and clear status flags |
| overrun_o | output | 1 | Sticky overrun flag |
| parity_err_o | output | 1 | Sticky parity error flag |
| framing_err_o | output | 1 | Sticky framing error flag |

## Verification
The bench injects a low pulse a few ticks long. A receiver that trusted the falling edge alone would store a false byte. It drives a frame with a low stop bit and follows it with a clean frame. A receiver that failed to wait for the line to go high would misframe the second character. It fills the queue to sixteen and sends one more character, then drains and compares all sixteen. A design that overwrote the newest or oldest entry, or let occupancy wrap to zero, would fail that comparison. It also sweeps the threshold select against a fixed occupancy. An off-by-one compare, or a swapped encoding, shows up as a wrong interrupt level.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;
  localparam int CHAR_W = 8;

  typedef enum logic [2:0] {
    RX_IDLE,
    RX_START,
    RX_DATA,
    RX_PAR,
    RX_STOP,
    RX_WAIT_HI
  } rx_state_e;

  typedef struct packed {
    logic [CHAR_W-1:0] data;
    logic              perr;
    logic              ferr;
  } rx_char_t;
endpackage

// File: rtl/uart_rx_sync.sv
module uart_rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sr_q <= '1;
    else         sr_q <= {sr_q[STAGES-2:0], d_i};
  end

  assign q_o = sr_q[STAGES-1];
endmodule

// File: rtl/uart_rx_deser.sv
module uart_rx_deser
  import uart_rx_pkg::*;
#(
  parameter int OVS = 16
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic       rx_i,
  input  logic [1:0] word_len_i,
  input  logic       par_en_i,
  input  logic       par_odd_i,
  output rx_char_t   char_o,
  output logic       done_o
);
  localparam int CNT_W = $clog2(OVS);
  localparam logic [CNT_W-1:0] HALF_LIM = CNT_W'(OVS/2 - 1);
  localparam logic [CNT_W-1:0] FULL_LIM = CNT_W'(OVS - 1);

  rx_state_e         state_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [2:0]        bit_q;
  logic [CHAR_W-1:0] shreg_q;
  logic              perr_q;
  logic              at_full;
  logic [2:0]        last_bit;

  assign at_full  = (cnt_q == FULL_LIM);
  assign last_bit = 3'd4 + {1'b0, word_len_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= RX_IDLE;
      cnt_q   <= '0;
      bit_q   <= '0;
      shreg_q <= '0;
      perr_q  <= 1'b0;
      char_o  <= '0;
      done_o  <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (tick_i) begin
        unique case (state_q)
          RX_IDLE: begin
            if (!rx_i) begin
              state_q <= RX_START;
              cnt_q   <= '0;
            end
          end
          RX_START: begin
            if (cnt_q == HALF_LIM) begin
              cnt_q <= '0;
              if (rx_i) begin
                state_q <= RX_IDLE;  // glitch
              end else begin
                state_q <= RX_DATA;
                bit_q   <= '0;
                shreg_q <= '0;
                perr_q  <= 1'b0;
              end
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
          RX_DATA: begin
            if (at_full) begin
              cnt_q          <= '0;
              shreg_q[bit_q] <= rx_i;
              if (bit_q == last_bit) state_q <= par_en_i ? RX_PAR : RX_STOP;
              else                   bit_q   <= bit_q + 1'b1;
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
          RX_PAR: begin
            if (at_full) begin
              cnt_q   <= '0;
              perr_q  <= rx_i ^ (^shreg_q) ^ par_odd_i;
              state_q <= RX_STOP;
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
          RX_STOP: begin
            if (at_full) begin
              cnt_q       <= '0;
              char_o.data <= shreg_q;
              char_o.perr <= perr_q;
              char_o.ferr <= !rx_i;
              done_o      <= 1'b1;
              state_q     <= rx_i ? RX_IDLE : RX_WAIT_HI;
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
          RX_WAIT_HI: begin
            if (rx_i) state_q <= RX_IDLE;
          end
          default: state_q <= RX_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/uart_rx_fifo.sv
module uart_rx_fifo #(
  parameter int DEPTH = 16,
  parameter int WIDTH = 8
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       push_i,
  input  logic [WIDTH-1:0]           wdata_i,
  input  logic                       pop_i,
  output logic [WIDTH-1:0]           rdata_o,
  output logic [$clog2(DEPTH):0]     count_o,
  output logic                       full_o,
  output logic                       empty_o
);
  localparam int PTR_W = $clog2(DEPTH);
  localparam int CNT_W = PTR_W + 1;

  logic [WIDTH-1:0] mem_q [DEPTH];
  logic [PTR_W-1:0] wr_ptr_q, rd_ptr_q;
  logic [CNT_W-1:0] cnt_q;
  logic             push_ok, pop_ok;

  assign full_o  = (cnt_q == CNT_W'(DEPTH));
  assign empty_o = (cnt_q == '0);
  assign push_ok = push_i && !full_o;
  assign pop_ok  = pop_i && !empty_o;
  assign rdata_o = mem_q[rd_ptr_q];
  assign count_o = cnt_q;

  always_ff @(posedge clk_i) begin
    if (push_ok) mem_q[wr_ptr_q] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      if (push_ok) wr_ptr_q <= wr_ptr_q + 1'b1;
      if (pop_ok)  rd_ptr_q <= rd_ptr_q + 1'b1;
      unique case ({push_ok, pop_ok})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end
endmodule

// File: rtl/uart_rx_buf.sv
module uart_rx_buf
  import uart_rx_pkg::*;
#(
  parameter int OVS         = 16,
  parameter int DEPTH       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    baud_tick_i,
  input  logic                    rx_i,
  input  logic [1:0]              word_len_i,
  input  logic                    par_en_i,
  input  logic                    par_odd_i,
  input  logic [1:0]              trig_sel_i,
  input  logic                    rd_i,
  output logic [CHAR_W-1:0]       rd_data_o,
  output logic                    empty_o,
  output logic [$clog2(DEPTH):0]  level_o,
  output logic                    irq_o,
  input  logic                    status_rd_i,
  output logic                    overrun_o,
  output logic                    parity_err_o,
  output logic                    framing_err_o
);
  localparam int LVL_W = $clog2(DEPTH) + 1;

  logic             rx_s;
  rx_char_t         rx_char;
  logic             char_done;
  logic             fifo_full;
  logic [LVL_W-1:0] trig_lvl;
  logic             ovr_q, perr_q, ferr_q;

  uart_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (rx_i),
    .q_o   (rx_s)
  );

  uart_rx_deser #(.OVS(OVS)) u_deser (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (baud_tick_i),
    .rx_i      (rx_s),
    .word_len_i(word_len_i),
    .par_en_i  (par_en_i),
    .par_odd_i (par_odd_i),
    .char_o    (rx_char),
    .done_o    (char_done)
  );

  uart_rx_fifo #(.DEPTH(DEPTH), .WIDTH(CHAR_W)) u_fifo (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .push_i (char_done),
    .wdata_i(rx_char.data),
    .pop_i  (rd_i),
    .rdata_o(rd_data_o),
    .count_o(level_o),
    .full_o (fifo_full),
    .empty_o(empty_o)
  );

  always_comb begin
    unique case (trig_sel_i)
      2'b00:   trig_lvl = LVL_W'(1);
      2'b01:   trig_lvl = LVL_W'(DEPTH/4);
      2'b10:   trig_lvl = LVL_W'(DEPTH/2);
      default: trig_lvl = LVL_W'(DEPTH);
    endcase
  end

  assign irq_o = (level_o >= trig_lvl);

  // sticky status, set beats clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ovr_q  <= 1'b0;
      perr_q <= 1'b0;
      ferr_q <= 1'b0;
    end else begin
      ovr_q  <= (char_done && fifo_full)    || (ovr_q  && !status_rd_i);
      perr_q <= (char_done && rx_char.perr) || (perr_q && !status_rd_i);
      ferr_q <= (char_done && rx_char.ferr) || (ferr_q && !status_rd_i);
    end
  end

  assign overrun_o     = ovr_q;
  assign parity_err_o  = perr_q;
  assign framing_err_o = ferr_q;
endmodule

// File: rtl/uart_rx_buf_chk.sv
module uart_rx_buf_chk #(
  parameter int DEPTH = 16
) (
  input logic                   clk_i,
  input logic                   rst_ni,
  input logic                   char_done,
  input logic                   fifo_full,
  input logic                   rd_i,
  input logic                   status_rd_i,
  input logic [$clog2(DEPTH):0] level_o,
  input logic                   empty_o,
  input logic                   irq_o,
  input logic                   overrun_o
);
  a_r10_level_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    level_o <= ($clog2(DEPTH)+1)'(DEPTH));

  a_r7_irq_at_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (level_o == ($clog2(DEPTH)+1)'(DEPTH)) |-> irq_o);

  a_r7_no_irq_empty: assert property (@(posedge clk_i) disable iff (!rst_ni)
    empty_o |-> !irq_o);

  a_r8_overrun_keeps: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (char_done && fifo_full && !rd_i) |=> (overrun_o && level_o == ($clog2(DEPTH)+1)'(DEPTH)));

  a_r6_push_grows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (char_done && !fifo_full && !rd_i) |=> (level_o == $past(level_o) + 1'b1));

  a_r6_pop_shrinks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && !empty_o && !char_done) |=> (level_o == $past(level_o) - 1'b1));

  a_r9_overrun_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (overrun_o && !status_rd_i) |=> overrun_o);
endmodule

bind uart_rx_buf uart_rx_buf_chk #(.DEPTH(DEPTH)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .char_done  (char_done),
  .fifo_full  (fifo_full),
  .rd_i       (rd_i),
  .status_rd_i(status_rd_i),
  .level_o    (level_o),
  .empty_o    (empty_o),
  .irq_o      (irq_o),
  .overrun_o  (overrun_o)
);

// File: tb/uart_rx_buf_tb.sv
module uart_rx_buf_tb;
  localparam int DEPTH   = 16;
  localparam int BIT_CLK = 64;  // 16 ticks x 4 clocks

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       baud_tick_i = 1'b0;
  logic       rx_i = 1'b1;
  logic [1:0] word_len_i = 2'b11;
  logic       par_en_i = 1'b0;
  logic       par_odd_i = 1'b0;
  logic [1:0] trig_sel_i = 2'b00;
  logic       rd_i = 1'b0;
  logic [7:0] rd_data_o;
  logic       empty_o;
  logic [4:0] level_o;
  logic       irq_o;
  logic       status_rd_i = 1'b0;
  logic       overrun_o, parity_err_o, framing_err_o;

  int n_chk = 0;
  int n_err = 0;
  bit mon_en = 1'b0;
  logic [7:0] exp_q[$];
  logic [1:0] tdiv = '0;

  always #5 clk_i = ~clk_i;

  always @(posedge clk_i) begin
    tdiv        <= tdiv + 1'b1;
    baud_tick_i <= (tdiv == 2'd3);
  end

  uart_rx_buf u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .baud_tick_i(baud_tick_i), .rx_i(rx_i),
    .word_len_i(word_len_i), .par_en_i(par_en_i), .par_odd_i(par_odd_i),
    .trig_sel_i(trig_sel_i), .rd_i(rd_i), .rd_data_o(rd_data_o),
    .empty_o(empty_o), .level_o(level_o), .irq_o(irq_o),
    .status_rd_i(status_rd_i), .overrun_o(overrun_o),
    .parity_err_o(parity_err_o), .framing_err_o(framing_err_o)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  task automatic line_bit(input logic v);
    rx_i = v;
    repeat (BIT_CLK) @(negedge clk_i);
  endtask

  task automatic send(input logic [7:0] d, input int nb, input bit pe, input bit podd,
                      input bit bad_par, input bit bad_stop, input bit keep);
    logic [7:0] dm;
    dm = d & 8'((1 << nb) - 1);
    word_len_i = 2'(nb - 5);
    par_en_i   = pe;
    par_odd_i  = podd;
    if (keep) exp_q.push_back(dm);
    line_bit(1'b0);
    for (int i = 0; i < nb; i++) line_bit(dm[i]);
    if (pe) line_bit((^dm) ^ podd ^ bad_par);
    line_bit(!bad_stop);
    if (bad_stop) line_bit(1'b1);
  endtask

  task automatic drain();
    for (int i = 0; i < 20000; i++) begin
      if (exp_q.size() == 0 && empty_o && !rd_i) break;
      @(negedge clk_i);
    end
    check(exp_q.size() == 0, "R6", "items left unreceived", exp_q.size(), 0);
  endtask

  task automatic ack_status();
    @(negedge clk_i) status_rd_i = 1'b1;
    @(negedge clk_i) status_rd_i = 1'b0;
  endtask

  // scoreboard monitor
  initial begin
    forever begin
      @(negedge clk_i);
      if (rd_i) begin
        rd_i = 1'b0;
      end else if (mon_en && !empty_o) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R6", "unexpected byte", int'(rd_data_o), -1);
        end else begin
          logic [7:0] e;
          e = exp_q.pop_front();
          check(rd_data_o == e, "R2/R6", "received byte", int'(rd_data_o), int'(e));
        end
        rd_i = 1'b1;
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    check(1'b0, "WDOG", "watchdog expired", 0, 1);
    finish_run();
  end

  initial begin
    repeat (5) @(negedge clk_i);
    // R1 reset state
    check(empty_o == 1'b1, "R1", "empty_o", empty_o, 1);
    check(level_o == 0, "R1", "level_o", level_o, 0);
    check(irq_o == 1'b0, "R1", "irq_o", irq_o, 0);
    check({overrun_o, parity_err_o, framing_err_o} == 3'b000, "R1", "status flags",
          {overrun_o, parity_err_o, framing_err_o}, 0);
    rst_ni = 1'b1;
    repeat (10) @(negedge clk_i);

    // R2 word lengths, R4 good parity
    mon_en = 1'b1;
    send(8'hA5, 8, 0, 0, 0, 0, 1);
    send(8'h3C, 8, 0, 0, 0, 0, 1);
    send(8'hF3, 5, 0, 0, 0, 0, 1);
    send(8'h6D, 6, 0, 0, 0, 0, 1);
    send(8'hDA, 7, 1, 0, 0, 0, 1);
    send(8'h2D, 6, 1, 1, 0, 0, 1);
    send(8'hB7, 8, 1, 1, 0, 0, 1);
    drain();
    check(parity_err_o == 1'b0, "R4", "parity_err_o on good parity", parity_err_o, 0);
    check(framing_err_o == 1'b0, "R5", "framing_err_o on good stop", framing_err_o, 0);

    // R4 parity mismatch, R9 clear
    send(8'h77, 8, 1, 0, 1, 0, 1);
    drain();
    check(parity_err_o == 1'b1, "R4", "parity_err_o after bad parity", parity_err_o, 1);
    repeat (50) @(negedge clk_i);
    check(parity_err_o == 1'b1, "R9", "parity_err_o held", parity_err_o, 1);
    ack_status();
    check(parity_err_o == 1'b0, "R9", "parity_err_o after ack", parity_err_o, 0);

    // R5 framing, then resume on clean frame
    send(8'h81, 8, 0, 0, 0, 1, 1);
    send(8'h42, 8, 0, 0, 0, 0, 1);
    drain();
    check(framing_err_o == 1'b1, "R5", "framing_err_o after low stop", framing_err_o, 1);
    ack_status();
    check(framing_err_o == 1'b0, "R9", "framing_err_o after ack", framing_err_o, 0);

    // R3 glitch rejection
    rx_i = 1'b0;
    repeat (12) @(negedge clk_i);
    rx_i = 1'b1;
    repeat (300) @(negedge clk_i);
    check(level_o == 0, "R3", "level_o after glitch", level_o, 0);
    check(empty_o == 1'b1, "R3", "empty_o after glitch", empty_o, 1);
    send(8'h99, 8, 0, 0, 0, 0, 1);
    drain();

    // R7 trigger thresholds, R10 level
    mon_en = 1'b0;
    trig_sel_i = 2'b01;
    for (int i = 0; i < 3; i++) send(8'(i * 17 + 3), 8, 0, 0, 0, 0, 1);
    repeat (4) @(negedge clk_i);
    check(level_o == 3, "R10", "level_o after 3", level_o, 3);
    check(irq_o == 1'b0, "R7", "irq_o at 3 of 4", irq_o, 0);
    send(8'(3 * 17 + 3), 8, 0, 0, 0, 0, 1);
    repeat (4) @(negedge clk_i);
    check(irq_o == 1'b1, "R7", "irq_o at 4 of 4", irq_o, 1);
    trig_sel_i = 2'b10;
    @(negedge clk_i);
    check(irq_o == 1'b0, "R7", "irq_o at 4 of 8", irq_o, 0);
    trig_sel_i = 2'b00;
    @(negedge clk_i);
    check(irq_o == 1'b1, "R7", "irq_o at 4 of 1", irq_o, 1);
    trig_sel_i = 2'b11;
    for (int i = 4; i < 15; i++) send(8'(i * 17 + 3), 8, 0, 0, 0, 0, 1);
    repeat (4) @(negedge clk_i);
    check(irq_o == 1'b0, "R7", "irq_o at 15 of 16", irq_o, 0);
    send(8'(15 * 17 + 3), 8, 0, 0, 0, 0, 1);
    repeat (4) @(negedge clk_i);
    check(irq_o == 1'b1, "R7", "irq_o at 16 of 16", irq_o, 1);
    check(level_o == 16, "R10", "level_o full", level_o, 16);

    // R8 overrun
    send(8'hEE, 8, 0, 0, 0, 0, 0);
    repeat (4) @(negedge clk_i);
    check(overrun_o == 1'b1, "R8", "overrun_o", overrun_o, 1);
    check(level_o == 16, "R8", "level_o after overrun", level_o, 16);
    repeat (100) @(negedge clk_i);
    check(overrun_o == 1'b1, "R9", "overrun_o held", overrun_o, 1);
    mon_en = 1'b1;
    drain();
    check(level_o == 0, "R10", "level_o after drain", level_o, 0);
    check(overrun_o == 1'b1, "R9", "overrun_o before ack", overrun_o, 1);
    ack_status();
    check(overrun_o == 1'b0, "R9", "overrun_o after ack", overrun_o, 0);

    finish_run();
  end
endmodule